// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32768 Hz time-base tick, delivered as a one-cycle clock enable on the system clock, into a slower periodic event. A 4-bit rate code picks the event period. Each period produces a rising edge on an internal square wave. That edge sets a sticky periodic flag, which a register-read strobe clears. The flag reaches the interrupt request only while the interrupt enable is high. The square wave itself can be routed to an output pin through a separate enable.

The rate code is not monotonic in frequency. Code 0 turns the generator off. Codes 1 and 2 are special slow rates of 256 Hz and 128 Hz. Codes 3 to 15 follow the halving rule, with a period of 2^(n-1) ticks. Whenever the code changes, the divider restarts, so the first period after a change always has its full length. The surrounding register file, the calendar logic and the other interrupt sources live outside this block.

Top module: `pirq_rate_gen`

## Requirements
- R1: With rate code 0, the flag is never set and `sqw_out` stays low.
- R2: For rate codes 3 to 15, the square wave and the flag repeat every 2^(code-1) time-base ticks. For example, code 3 repeats every 4 ticks and code 15 every 16384 ticks.
- R3: Code 1 repeats every 128 ticks (256 Hz) and code 2 repeats every 256 ticks (128 Hz).
- R4: The flag is set in the clock cycle that follows a rising edge of the internal square wave, and it stays set until cleared. If a set and `flag_clr` fall in the same cycle, the flag ends up set.
- R5: A one-cycle `flag_clr` pulse clears the flag on the next clock edge when no new edge coincides with it.
- R6: `irq` equals the flag while `pie_en` is 1 and is 0 while `pie_en` is 0. There is no register between `pie_en` and `irq`.
- R7: While `sqw_en` is 1, `sqw_out` shows the square wave, which is high for the first half of every period. While `sqw_en` is 0, `sqw_out` is held low.
- R8: A change of `rate_sel` takes effect on the next clock edge and restarts the divider. The first flag after the change comes exactly one full period of ticks after that edge, and the square wave is high during the first half of that period.
- R9: While `rst_n` is 0 at a clock edge, the flag is cleared and the divider is cleared. After that edge, `pflag`, `irq` and `sqw_out` read 0.
- R10: While `tick_en` is 0, the square wave holds its level and no new flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle enable at the 32768 Hz time-base rate |
| rate_sel | input | 4 | Rate code |
| pie_en | input | 1 | Lets the flag drive `irq` |
| sqw_en | input | 1 | Routes the square wave to `sqw_out` |
| flag_clr | input | 1 | Clear strobe from a read of the flag |
| pflag | output | 1 | Sticky periodic flag |
| irq | output | 1 | Gated interrupt request |
| sqw_out | output | 1 | Square wave at the selected rate, or low |

## Verification
The square-wave period is measured between successive rising edges for codes 3, 15, 1 and 2. Code 3 and code 15 pin the general halving rule at its two ends. Codes 1 and 2 show whether the slow-rate override is decoded instead of being treated as an extension of that rule.

A switch from code 3 to code 4 with the flag cleared separates a divider that restarts from one that merely retaps a running counter. Only a restart gives a first flag after exactly one full period.

A continuous clear strobe while code 3 runs shows that a set wins over a coincident clear. Runs with code 0, with `tick_en` held low, and with each enable dropped show that those inputs freeze or mask only what they should. A behavioural model is compared against all three outputs on every cycle.

// File: rtl/pirq_pkg.sv
// Package pirq_pkg
// Shared sizes and types for the periodic interrupt rate generator.
// Assumes a 32768 Hz time base. A 15-bit divider therefore covers
// one second of ticks.
package pirq_pkg;
    localparam int CODE_W   = 4;   // width of the rate code
    localparam int DIV_W    = 15;  // divider width in ticks
    localparam int SLOW1_TAP = 6;  // code 1: 128-tick period
    localparam int SLOW2_TAP = 7;  // code 2: 256-tick period

    typedef logic [CODE_W-1:0] rate_code_t;
endpackage

// File: rtl/pirq_rate_map.sv
// Module pirq_rate_map
// Turns a rate code into a divider bit index (tap) and an active flag.
// The square wave on divider bit k has a period of 2^(k+1) ticks.
//
// Assumes a purely combinational use.
// SLOW_OVERRIDE picks one of two decodes for codes 1 and 2:
// - set to 1: codes 1 and 2 map to the fixed slow taps;
// - set to 0: code 2 follows the general rule and code 1 is inactive.
module pirq_rate_map #(
    parameter int SEL_W         = pirq_pkg::CODE_W,
    parameter int DIV_W         = pirq_pkg::DIV_W,
    parameter int TAP_W         = $clog2(DIV_W),
    parameter bit SLOW_OVERRIDE = 1'b1,
    parameter int SLOW1_TAP     = pirq_pkg::SLOW1_TAP,
    parameter int SLOW2_TAP     = pirq_pkg::SLOW2_TAP
) (
    input  logic [SEL_W-1:0] code,
    output logic             active,
    output logic [TAP_W-1:0] tap
);
    // Tap index that the general halving rule gives: code minus two.
    int gen_tap;

    // Compute the general-rule tap from the code.
    always_comb begin
        gen_tap = int'(code) - 2;
    end

    generate
        if (SLOW_OVERRIDE) begin : g_slow_ovr
            // Decode with the fixed slow rates for codes 1 and 2.
            always_comb begin
                if (code == '0) begin
                    active = 1'b0;
                    tap    = '0;
                end else if (code == SEL_W'(1)) begin
                    active = 1'b1;
                    tap    = TAP_W'(SLOW1_TAP);
                end else if (code == SEL_W'(2)) begin
                    active = 1'b1;
                    tap    = TAP_W'(SLOW2_TAP);
                end else begin
                    active = (gen_tap < DIV_W);
                    tap    = TAP_W'(gen_tap);
                end
            end
        end else begin : g_plain
            // Decode with the general rule everywhere it yields a tap.
            always_comb begin
                active = (code != '0) && (gen_tap >= 0) && (gen_tap < DIV_W);
                tap    = active ? TAP_W'(gen_tap) : '0;
            end
        end
    endgenerate
endmodule

// File: rtl/pirq_divider.sv
// Module pirq_divider
// Free-running divider that counts time-base ticks and produces the
// square wave and the one-cycle set pulse for the periodic flag.
//
// Assumes that tick_en is a one-cycle enable in the clk domain.
// A change of code reloads the divider with only the new tap bit set,
// so the first rising edge after a change comes a full period later.
module pirq_divider #(
    parameter int SEL_W = pirq_pkg::CODE_W,
    parameter int DIV_W = pirq_pkg::DIV_W,
    parameter int TAP_W = $clog2(DIV_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             sqw_raw,
    output logic             set_pulse
);
    logic [SEL_W-1:0] rate_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cnt_nxt;
    logic [DIV_W-1:0] load_val;
    logic             rate_chg;
    logic             act_new;
    logic             act_cur;
    logic [TAP_W-1:0] tap_new;
    logic [TAP_W-1:0] tap_cur;

    // Decode for the incoming code, which gives the reload value.
    pirq_rate_map #(.SEL_W(SEL_W), .DIV_W(DIV_W), .TAP_W(TAP_W)) u_map_new (
        .code   (rate_sel),
        .active (act_new),
        .tap    (tap_new)
    );

    // Decode for the code in force, which gives the tap in use.
    pirq_rate_map #(.SEL_W(SEL_W), .DIV_W(DIV_W), .TAP_W(TAP_W)) u_map_cur (
        .code   (rate_q),
        .active (act_cur),
        .tap    (tap_cur)
    );

    // Detect a code change and form the next and reload values.
    always_comb begin
        rate_chg = (rate_sel != rate_q);
        cnt_nxt  = cnt_q + DIV_W'(1);
        load_val = act_new ? (DIV_W'(1) << tap_new) : '0;
    end

    // Hold the code in force and advance or reload the divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
            cnt_q  <= '0;
        end else if (rate_chg) begin
            rate_q <= rate_sel;
            cnt_q  <= load_val;
        end else if (tick_en) begin
            cnt_q  <= cnt_nxt;
        end
    end

    // Tap the square wave and find its rising edge on a tick.
    always_comb begin
        sqw_raw   = act_cur & cnt_q[tap_cur];
        set_pulse = tick_en & ~rate_chg & act_cur
                    & ~cnt_q[tap_cur] & cnt_nxt[tap_cur];
    end

    // R10: no tick and no code change leave the divider frozen.
    a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && rate_sel == rate_q) |=> $stable(cnt_q));
endmodule

// File: rtl/pirq_flag.sv
// Module pirq_flag
// Sticky periodic flag with a clear strobe, plus the enable gate for
// the interrupt request.
//
// Assumes that the clear strobe is one cycle long and comes from a
// register read. When a set and a clear arrive in the same cycle, the
// set wins, so no period is lost.
module pirq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic flag_clr,
    input  logic pie_en,
    output logic pflag,
    output logic irq
);
    logic flag_q;

    // Set on a period edge, clear on the strobe, set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_pulse)
            flag_q <= 1'b1;
        else if (flag_clr)
            flag_q <= 1'b0;
    end

    // Drive the flag and the enable-gated request.
    always_comb begin
        pflag = flag_q;
        irq   = flag_q & pie_en;
    end

    // R4: a period edge leaves the flag set, even with a clear present.
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> pflag);

    // R5: a clear with no coincident edge drops the flag.
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !set_pulse) |=> !pflag);
endmodule

// File: rtl/pirq_rate_gen.sv
// Module pirq_rate_gen
// Top of the periodic interrupt rate generator. Divides the time-base
// tick by the selected code and produces the sticky flag, the gated
// request and the optional square-wave pin.
//
// Assumes that all inputs are synchronous to clk.
// The reset is synchronous and active low.
module pirq_rate_gen #(
    parameter int SEL_W = pirq_pkg::CODE_W,
    parameter int DIV_W = pirq_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             pie_en,
    input  logic             sqw_en,
    input  logic             flag_clr,
    output logic             pflag,
    output logic             irq,
    output logic             sqw_out
);
    localparam int TAP_W = $clog2(DIV_W);

    logic sqw_raw;
    logic set_pulse;

    // Divider and edge finder.
    pirq_divider #(.SEL_W(SEL_W), .DIV_W(DIV_W), .TAP_W(TAP_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .rate_sel  (rate_sel),
        .sqw_raw   (sqw_raw),
        .set_pulse (set_pulse)
    );

    // Flag and request gate.
    pirq_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (set_pulse),
        .flag_clr  (flag_clr),
        .pie_en    (pie_en),
        .pflag     (pflag),
        .irq       (irq)
    );

    // Route the square wave to the pin, or hold the pin low.
    always_comb begin
        sqw_out = sqw_en & sqw_raw;
    end

    // R1: code 0 at an edge never lets the flag rise at that edge.
    a_r1_off_code_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0) |=> !$rose(pflag));
endmodule

// File: tb/pirq_rate_gen_tb_top.sv
// Bench for pirq_rate_gen. A behavioural model holds the period
// position as an integer and is compared with the outputs on every
// falling edge. Directed checks then measure periods and edge cases.
module pirq_rate_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       pie_en = 1'b0;
    logic       sqw_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       pflag, irq, sqw_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Model state.
    int m_rate = 0;
    int m_pos  = 0;
    bit m_flag = 1'b0;
    bit m_live = 1'b0;

    always #4 clk = ~clk;

    pirq_rate_gen dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_sel(rate_sel),
        .pie_en(pie_en), .sqw_en(sqw_en), .flag_clr(flag_clr),
        .pflag(pflag), .irq(irq), .sqw_out(sqw_out)
    );

    function automatic int period_of(int c);
        if (c == 0) return 0;
        if (c == 1) return 128;
        if (c == 2) return 256;
        return 1 << (c - 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_rate = 0; m_pos = 0; m_flag = 1'b0;
        end else if (int'(rate_sel) != m_rate) begin
            m_rate = int'(rate_sel);
            m_pos  = 0;
            m_flag = m_flag && !flag_clr;
        end else begin
            bit s;
            s = 1'b0;
            if (tick_en && m_rate != 0) begin
                m_pos = (m_pos + 1) % period_of(m_rate);
                s = (m_pos == 0);
            end
            m_flag = s || (m_flag && !flag_clr);
        end
        m_live = 1'b1;
    end

    // Comparison on every falling edge.
    always @(negedge clk) begin
        if (m_live && !done) begin
            bit e_sqw;
            e_sqw = sqw_en && m_rate != 0 && (m_pos < period_of(m_rate) / 2);
            check(pflag == m_flag, "R4 model pflag", int'(pflag), int'(m_flag));
            check(irq == (m_flag && pie_en), "R6 model irq", int'(irq), int'(m_flag && pie_en));
            check(sqw_out == e_sqw, "R7 model sqw_out", int'(sqw_out), int'(e_sqw));
        end
    end

    task automatic drive_step();
        @(posedge clk);
        #2;
    endtask

    // Measure the negedges between two rising edges of sqw_out.
    task automatic sqw_period(input logic [3:0] code, input int exp_p, input string req);
        int n;
        bit prev;
        drive_step();
        rate_sel = code;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (!prev && sqw_out) break;
            prev = sqw_out;
        end
        n = 0;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            n++;
            if (!prev && sqw_out) break;
            prev = sqw_out;
        end
        check(n == exp_p, req, n, exp_p);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 180000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 180000);
            finish_run();
        end
    end

    initial begin
        int n;
        int highs;
        bit held;
        repeat (3) drive_step();
        // R9: reset state
        @(negedge clk);
        check(pflag == 1'b0, "R9 reset pflag", int'(pflag), 0);
        check(irq == 1'b0, "R9 reset irq", int'(irq), 0);
        check(sqw_out == 1'b0, "R9 reset sqw_out", int'(sqw_out), 0);
        drive_step();
        rst_n = 1'b1; tick_en = 1'b1; sqw_en = 1'b1; pie_en = 1'b1;

        // R2: general rule at both ends; R3: slow overrides
        sqw_period(4'd3, 4, "R2 code 3 period");
        sqw_period(4'd15, 16384, "R2 code 15 period");
        sqw_period(4'd1, 128, "R3 code 1 period");
        sqw_period(4'd2, 256, "R3 code 2 period");
        sqw_period(4'd3, 4, "R2 code 3 period again");

        // R8: change from 3 to 4 with a clear, then count to the first flag
        drive_step();
        rate_sel = 4'd4; flag_clr = 1'b1;
        drive_step();
        flag_clr = 1'b0;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1) check(sqw_out == 1'b1, "R8 sqw high after change", int'(sqw_out), 1);
            if (pflag || n > 100) break;
        end
        check(n == 9, "R8 first flag after full period", n, 9);

        // R6: request gate
        drive_step();
        pie_en = 1'b0;
        @(negedge clk);
        check(pflag == 1'b1 && irq == 1'b0, "R6 irq masked", int'(irq), 0);
        drive_step();
        pie_en = 1'b1;
        @(negedge clk);
        check(irq == 1'b1, "R6 irq follows flag", int'(irq), 1);

        // R5: clear strobe drops the flag (code 4 has no edge this soon)
        drive_step();
        flag_clr = 1'b1;
        drive_step();
        flag_clr = 1'b0;
        @(negedge clk);
        check(pflag == 1'b0, "R5 flag cleared", int'(pflag), 0);

        // R4: clear held high with code 3; a set still shows for a cycle
        drive_step();
        rate_sel = 4'd3; flag_clr = 1'b1;
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pflag) highs++;
        end
        check(highs >= 9, "R4 set wins over clear", highs, 9);
        drive_step();
        flag_clr = 1'b0;

        // R7: pin held low while disabled
        drive_step();
        sqw_en = 1'b0;
        held = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (sqw_out) held = 1'b0;
        end
        check(held, "R7 sqw_out low when disabled", int'(!held), 0);
        drive_step();
        sqw_en = 1'b1;

        // R10: no ticks -> level frozen, no new flag
        drive_step();
        flag_clr = 1'b1;
        drive_step();
        flag_clr = 1'b0; tick_en = 1'b0;
        @(negedge clk);
        held = sqw_out;
        n = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (sqw_out != held || pflag) n++;
        end
        check(n == 0, "R10 frozen without ticks", n, 0);
        drive_step();
        tick_en = 1'b1;

        // R1: code 0 produces nothing
        drive_step();
        rate_sel = 4'd0; flag_clr = 1'b1;
        drive_step();
        flag_clr = 1'b0;
        n = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (pflag || sqw_out) n++;
        end
        check(n == 0, "R1 code 0 silent", n, 0);

        // R9: reset mid-run clears the flag
        drive_step();
        rate_sel = 4'd3;
        repeat (10) drive_step();
        rst_n = 1'b0;
        drive_step();
        @(negedge clk);
        check(pflag == 1'b0 && sqw_out == 1'b0, "R9 reset mid-run", int'(pflag), 0);
        drive_step();
        rst_n = 1'b1;
        repeat (20) drive_step();

        finish_run();
    end
endmodule